// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked single-beat request port and an external asynchronous static RAM of 512K bytes. The RAM has one shared data bus for both directions. Each accepted request becomes one strobe sequence on three active-low pins: chip select, output enable and write strobe. Each phase of that sequence lasts a whole number of clock cycles. The phase lengths come from nanosecond limits, which are parameters, divided by the clock period parameter and rounded up. A different speed grade or clock therefore needs only new parameter values.

The RAM side uses a split tri-state: an output byte, a drive-enable and an input byte. The pad ring merges these into the shared bus. The controller decides when it owns the bus. It never drives while the RAM could be driving, and it keeps driving the write byte past the rising edge of the write strobe. A read returns its byte with a one-cycle valid pulse. A write returns a one-cycle done pulse after its recovery phase.

Top module: `asram_port`

## Requirements
- R1: During reset and just after it, ready is 1. The chip-select, output-enable and write-strobe pins (all active low) are 1. The drive-enable is 0, and both the read-valid and write-done pulses are 0. A reset in the middle of a write returns the pins to this state.
- R2: A request is taken only on a clock edge where both req and ready are 1. ready falls for the whole transaction. A req held high while busy starts no further access, and its address and data are never used.
- R3: A read holds chip select and output enable low, with the write strobe high, for N_ACC cycles. The input byte is sampled on the last of those cycles. In the next cycle rd_valid is high for exactly one cycle, with the strobes released.
- R4: A write holds chip select low with the write strobe high for N_AS setup cycles. It then holds the write strobe low for N_PULSE cycles. Output enable stays high for the whole write.
- R5: The drive-enable is 1 only while output enable is high. It is 0 in the first N_WZ cycles of the write pulse. It is 1 in the last N_PULSE-N_WZ pulse cycles and in the recovery cycles.
- R6: While chip select is low, the address pins do not change. While the write strobe is low, the output data byte does not change.
- R7: wr_done is high for exactly one cycle, in the first idle cycle after recovery, with ready high in that cycle.
- R8: Each phase length is the nanosecond limit divided by CLK_PERIOD_NS and rounded up, with a minimum of 1. The read access is the larger of the access-time and read-cycle limits. The pulse is the largest of three values: the pulse-width limit, N_WZ+N_DW, and the chip-select limit minus N_AS. The recovery is the write-cycle limit minus setup and pulse, with a minimum of 1. From the accepting edge, rd_valid appears after N_ACC+1 cycles. wr_done appears after N_AS+N_PULSE+N_REC+1 cycles.
- R9: rd_data keeps the last byte read until the next read completes. Writes do not change it.
- R10: Chip select is high in every cycle where ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| ready | output | 1 | Idle, can take a request |
| rd_valid | output | 1 | One-cycle pulse, rd_data fresh |
| rd_data | output | 8 | Last byte read |
| wr_done | output | 1 | One-cycle pulse, write finished |
| mem_addr | output | 19 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | 8 | Byte for the pad to drive |
| mem_dq_drive | output | 1 | Pad drive-enable |
| mem_dq_in | input | 8 | Byte seen on the shared bus |

## Verification
Some properties hold on every cycle, and the assertions check these:
- The bus is never driven while output enable is low, and no write pulse ever shows output enable low.
- Chip select is high whenever the block is idle.
- The address stays frozen under chip select, and the write byte stays frozen under the write strobe.
- The bus is not driven on the cycle the write strobe falls, and is driven on the cycle it rises.
- The valid and done pulses last a single cycle.

Other behaviour can only be shown by the bench scenarios against a memory model on the shared bus:
- the exact cycle counts of each phase;
- that the bytes written come back on later reads;
- that requests made while busy leave the memory untouched;
- that rd_data survives writes;
- that reset recovers mid-write.

// File: rtl/asram_pkg.sv
// Shared types and cycle arithmetic for the asynchronous RAM sequencer.
// Assumes all timing limits are non-negative nanosecond integers.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_RD_CAPTURE = 3'd2,
        ST_WR_SETUP   = 3'd3,
        ST_WR_PULSE   = 3'd4,
        ST_WR_RECOVER = 3'd5
    } seq_state_t;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        int unsigned c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    // Larger of two counts.
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
// Down-counter that times one phase of the strobe sequence.
// Loading value L makes 'last' high in the L+1-th cycle after the load edge.
// Assumes the sequencer loads it on every phase entry that needs timing.
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Load a fresh phase length or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
// Strobe sequencer: walks idle, read access/capture and write
// setup/pulse/recover. Decodes the active-low RAM strobes, the bus
// drive-enable and the user handshake from the state register.
// Assumes phase counts are at least one and N_PULSE > N_WZ.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int N_ACC   = 5,
    parameter int N_AS    = 1,
    parameter int N_PULSE = 5,
    parameter int N_WZ    = 2,
    parameter int N_REC   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             req_we,
    input  logic             t_last,
    input  logic [CNT_W-1:0] t_count,
    output logic             t_load,
    output logic [CNT_W-1:0] t_load_val,
    output logic             ready,
    output logic             accept,
    output logic             capture,
    output logic             rd_valid,
    output logic             wr_done,
    output logic             ce_n,
    output logic             oe_n,
    output logic             we_n,
    output logic             drive
);

    localparam logic [CNT_W-1:0] DRV_LIMIT = CNT_W'(N_PULSE - N_WZ);

    seq_state_t state_q, state_d;
    logic       done_q;

    // Next-state and phase-timer load decisions.
    always_comb begin
        state_d    = state_q;
        t_load     = 1'b0;
        t_load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    t_load = 1'b1;
                    if (req_we) begin
                        state_d    = ST_WR_SETUP;
                        t_load_val = CNT_W'(N_AS - 1);
                    end else begin
                        state_d    = ST_RD_ACCESS;
                        t_load_val = CNT_W'(N_ACC - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (t_last) state_d = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                state_d = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (t_last) begin
                    state_d    = ST_WR_PULSE;
                    t_load     = 1'b1;
                    t_load_val = CNT_W'(N_PULSE - 1);
                end
            end
            ST_WR_PULSE: begin
                if (t_last) begin
                    state_d    = ST_WR_RECOVER;
                    t_load     = 1'b1;
                    t_load_val = CNT_W'(N_REC - 1);
                end
            end
            ST_WR_RECOVER: begin
                if (t_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Write completion pulse, raised as recovery ends.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_WR_RECOVER) && t_last;
    end

    // Handshake and strobe decode from the current state.
    always_comb begin
        ready    = (state_q == ST_IDLE);
        accept   = ready && req;
        capture  = (state_q == ST_RD_ACCESS) && t_last;
        rd_valid = (state_q == ST_RD_CAPTURE);
        wr_done  = done_q;
        ce_n     = !((state_q == ST_RD_ACCESS) || (state_q == ST_WR_SETUP) ||
                     (state_q == ST_WR_PULSE)  || (state_q == ST_WR_RECOVER));
        oe_n     = !(state_q == ST_RD_ACCESS);
        we_n     = !(state_q == ST_WR_PULSE);
        drive    = ((state_q == ST_WR_PULSE) && (t_count < DRV_LIMIT)) ||
                   (state_q == ST_WR_RECOVER);
    end

endmodule

// File: rtl/asram_datapath.sv
// Holds the request address and write byte for the whole access and
// captures the read byte from the bus. Assumes 'accept' only in idle.
module asram_datapath #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] rd_data
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    // Latch the request so the pins stay frozen during the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Sample the RAM byte at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= bus_in;
    end

    assign mem_addr = addr_q;
    assign bus_out  = wdata_q;
    assign rd_data  = rdata_q;

endmodule

// File: rtl/asram_port.sv
// Top of the asynchronous RAM sequencer. Turns nanosecond limits into
// phase cycle counts and wires the timer, sequencer and datapath together.
// Assumes the pad ring merges mem_dq_out/mem_dq_drive/mem_dq_in into the
// shared bus, and that strobes decoded from one state register are clean
// enough at the pads.
module asram_port
    import asram_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_ACC_NS      = 45,
    parameter int T_RC_NS       = 45,
    parameter int T_AS_NS       = 0,
    parameter int T_CW_NS       = 35,
    parameter int T_WP_NS       = 35,
    parameter int T_WZ_NS       = 18,
    parameter int T_DW_NS       = 25,
    parameter int T_WC_NS       = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ready,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drive,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int unsigned C_ACC = ns_to_cycles(T_ACC_NS, CLK_PERIOD_NS);
    localparam int unsigned C_RC  = ns_to_cycles(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_AS  = ns_to_cycles(T_AS_NS, CLK_PERIOD_NS);
    localparam int unsigned C_CW  = ns_to_cycles(T_CW_NS, CLK_PERIOD_NS);
    localparam int unsigned C_WP  = ns_to_cycles(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned N_WZ  = ns_to_cycles(T_WZ_NS, CLK_PERIOD_NS);
    localparam int unsigned C_DW  = ns_to_cycles(T_DW_NS, CLK_PERIOD_NS);
    localparam int unsigned C_WC  = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned N_ACC = max_u(C_ACC, C_RC);
    localparam int unsigned C_CWP = (C_CW > N_AS) ? (C_CW - N_AS) : 1;
    localparam int unsigned N_PULSE = max_u(max_u(C_WP, N_WZ + C_DW), C_CWP);
    localparam int unsigned N_REC = (C_WC > N_AS + N_PULSE) ? (C_WC - N_AS - N_PULSE) : 1;
    localparam int unsigned N_MAX = max_u(max_u(N_ACC, N_AS), max_u(N_PULSE, N_REC));
    localparam int CNT_W = $clog2(N_MAX + 1) + 1;

    logic             t_load;
    logic             t_last;
    logic [CNT_W-1:0] t_load_val;
    logic [CNT_W-1:0] t_count;
    logic             accept;
    logic             capture;

    asram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_load_val),
        .count    (t_count),
        .last     (t_last)
    );

    asram_seq #(
        .CNT_W   (CNT_W),
        .N_ACC   (int'(N_ACC)),
        .N_AS    (int'(N_AS)),
        .N_PULSE (int'(N_PULSE)),
        .N_WZ    (int'(N_WZ)),
        .N_REC   (int'(N_REC))
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .req_we     (req_we),
        .t_last     (t_last),
        .t_count    (t_count),
        .t_load     (t_load),
        .t_load_val (t_load_val),
        .ready      (ready),
        .accept     (accept),
        .capture    (capture),
        .rd_valid   (rd_valid),
        .wr_done    (wr_done),
        .ce_n       (mem_ce_n),
        .oe_n       (mem_oe_n),
        .we_n       (mem_we_n),
        .drive      (mem_dq_drive)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (mem_dq_in),
        .mem_addr  (mem_addr),
        .bus_out   (mem_dq_out),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/asram_port_chk.sv
// Cycle-by-cycle protocol checks for asram_port, attached by bind.
// Assumes only the top-level ports; reads no internal state.
module asram_port_chk #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic              ready,
    input logic              rd_valid,
    input logic              wr_done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_drive
);

    p_idle_standby_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> mem_ce_n);

    p_take_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    p_valid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_valid_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (mem_oe_n && mem_we_n));

    p_write_oe_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_drive |-> mem_oe_n);

    p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_drive);

    p_hold_past_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_we_n) && !mem_ce_n) |-> mem_dq_drive);

    p_addr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    p_wdata_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done);

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> ready);

endmodule

bind asram_port asram_port_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .ready        (ready),
    .rd_valid     (rd_valid),
    .wr_done      (wr_done),
    .mem_addr     (mem_addr),
    .mem_ce_n     (mem_ce_n),
    .mem_oe_n     (mem_oe_n),
    .mem_we_n     (mem_we_n),
    .mem_dq_out   (mem_dq_out),
    .mem_dq_drive (mem_dq_drive)
);

// File: tb/asram_port_test.sv
// Bench: a behavioural RAM model on the shared bus, a vector table of
// writes and reads, then directed tests for busy requests, rd_data
// retention and reset during a write.
module asram_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    // Expected phase counts worked out from the timing limits.
    function automatic int cyc(input int ns);
        int c;
        c = (ns + CLK_PERIOD - 1) / CLK_PERIOD;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int E_ACC   = (cyc(45) > cyc(45)) ? cyc(45) : cyc(45);
    localparam int E_AS    = cyc(0);
    localparam int E_WZ    = cyc(18);
    localparam int E_DW    = cyc(25);
    localparam int E_PULSE = (cyc(35) > E_WZ + E_DW) ? cyc(35) : E_WZ + E_DW;
    localparam int E_REC   = (cyc(45) > E_AS + E_PULSE) ? cyc(45) - E_AS - E_PULSE : 1;
    localparam int E_RD_LAT = E_ACC + 1;
    localparam int E_WR_LAT = E_AS + E_PULSE + E_REC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        ready, rd_valid, wr_done;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_drive;
    logic [7:0]  mem_dq_out;
    logic [7:0]  bus;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] model [256];
    logic       op_active = 1'b0;
    int cnt_oe, cnt_we, cnt_drv, cnt_clash;

    asram_port uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .ready        (ready),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .wr_done      (wr_done),
        .mem_addr     (mem_addr),
        .mem_ce_n     (mem_ce_n),
        .mem_oe_n     (mem_oe_n),
        .mem_we_n     (mem_we_n),
        .mem_dq_out   (mem_dq_out),
        .mem_dq_drive (mem_dq_drive),
        .mem_dq_in    (bus)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Shared bus: controller byte, else RAM byte when it reads, else zero.
    always_comb begin
        if (mem_dq_drive)                              bus = mem_dq_out;
        else if (!mem_ce_n && !mem_oe_n && mem_we_n)   bus = model[mem_addr[7:0]];
        else                                           bus = 8'h00;
    end

    // RAM model stores on the rising write strobe while selected.
    always @(posedge mem_we_n) begin
        if (mem_ce_n === 1'b0) model[mem_addr[7:0]] <= bus;
    end

    // Per-operation strobe bookkeeping, sampled mid-cycle.
    always @(negedge clk) begin
        if (op_active) begin
            if (!mem_oe_n) cnt_oe++;
            if (!mem_we_n) cnt_we++;
            if (!mem_we_n && mem_dq_drive) cnt_drv++;
            if (mem_dq_drive && !mem_oe_n) cnt_clash++;
        end
    end

    task automatic finish_up();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
            finish_up();
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One request through the handshake, with timing and data checks.
    task automatic run_op(input logic we, input logic [18:0] a,
                          input logic [7:0] d, input logic [7:0] exp);
        int lat;
        @(negedge clk);
        cnt_oe = 0; cnt_we = 0; cnt_drv = 0; cnt_clash = 0;
        chk(ready == 1'b1, "R2 ready before request", int'(ready), 1);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        op_active = 1'b1;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        chk(mem_addr == a, "R6 address pins", int'(mem_addr), int'(a));
        while (!(rd_valid || wr_done) && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        op_active = 1'b0;
        if (!we) begin
            chk(rd_data == exp, "R3 read byte", int'(rd_data), int'(exp));
            chk(cnt_oe == E_ACC, "R3 access cycles", cnt_oe, E_ACC);
            chk(lat == E_RD_LAT, "R8 read latency", lat, E_RD_LAT);
        end else begin
            chk(cnt_we == E_PULSE, "R4 pulse cycles", cnt_we, E_PULSE);
            chk(cnt_drv == E_PULSE - E_WZ, "R5 driven pulse cycles", cnt_drv, E_PULSE - E_WZ);
            chk(cnt_clash == 0, "R5 bus contention", cnt_clash, 0);
            chk(lat == E_WR_LAT, "R8 write latency", lat, E_WR_LAT);
            chk(ready == 1'b1, "R7 ready with done", int'(ready), 1);
        end
        @(negedge clk);
        chk(!rd_valid && !wr_done, "R7 single-cycle pulse", int'({rd_valid, wr_done}), 0);
    endtask

    // {write, address, write byte, expected read byte}
    localparam logic [35:0] VEC [8] = '{
        {1'b1, 19'h00011, 8'hA5, 8'h00},
        {1'b1, 19'h7FF22, 8'h3C, 8'h00},
        {1'b1, 19'h00000, 8'hFF, 8'h00},
        {1'b0, 19'h00011, 8'h00, 8'hA5},
        {1'b0, 19'h7FF22, 8'h00, 8'h3C},
        {1'b1, 19'h00011, 8'h5A, 8'h00},
        {1'b0, 19'h00011, 8'h00, 8'h5A},
        {1'b0, 19'h00000, 8'h00, 8'hFF}
    };

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;

        // R1: state while reset is held.
        repeat (3) @(negedge clk);
        chk(ready && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_drive &&
            !rd_valid && !wr_done, "R1 reset state",
            int'({ready, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_drive, rd_valid, wr_done}),
            7'b1111000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n == 1'b1, "R10 idle standby", int'(mem_ce_n), 1);

        // Vector table: R3 R4 R5 R6 R7 R8.
        for (int v = 0; v < 8; v++) begin
            run_op(VEC[v][35], VEC[v][34:16], VEC[v][15:8], VEC[v][7:0]);
        end

        // R2: req held high while busy with other address/data.
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 19'h00033; req_wdata = 8'h77;
        @(negedge clk);
        req_addr = 19'h00044; req_wdata = 8'h99;
        @(negedge clk);
        chk(mem_addr == 19'h00033, "R6 address held while busy", int'(mem_addr), 'h33);
        while (!wr_done) @(negedge clk);
        req = 1'b0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk(mem_ce_n == 1'b1 && ready, "R2 no second access", int'(mem_ce_n), 1);
        end
        run_op(1'b0, 19'h00044, 8'h00, 8'h00);
        run_op(1'b0, 19'h00033, 8'h00, 8'h77);

        // R9: rd_data survives a write.
        run_op(1'b1, 19'h00055, 8'h12, 8'h00);
        chk(rd_data == 8'h77, "R9 rd_data kept across write", int'(rd_data), 'h77);
        run_op(1'b0, 19'h00055, 8'h00, 8'h12);
        chk(rd_data == 8'h12, "R9 rd_data replaced by read", int'(rd_data), 'h12);

        // R1: reset in the middle of a write pulse.
        @(negedge clk);
        req = 1'b1; req_we = 1'b1; req_addr = 19'h00066; req_wdata = 8'h44;
        @(negedge clk);
        req = 1'b0;
        repeat (2) @(negedge clk);
        chk(mem_we_n == 1'b0, "R4 pulse under way", int'(mem_we_n), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(ready && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive,
            "R1 reset mid-write", int'({ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}),
            5'b11110);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(1'b0, 19'h00011, 8'h00, 8'h5A);

        finish_up();
    end

endmodule